// File: doc/BRIEF.md
# Circular-Buffer Delay Segment for Time-Multiplexed FIR Filters

This block is one link of the sample delay line inside a time-multiplexed FIR filter, where a single multiply-accumulate datapath serves many taps. A new input sample arrives once every few clock cycles. Each delay element of the direct-form line is therefore replaced by a small circular buffer that holds `DEPTH` samples. For a dense filter `DEPTH` is the time-multiplexing factor. For a sparse periodic filter it is that factor times the sparsity period. Segments are chained so that together they reproduce one long delay line.

Every cycle the segment performs one write and two reads. The first read port is the tap port. An external read counter supplies a physical address, and the stored sample comes back one cycle later. When that address is being written in the same cycle, the tap port returns the old contents. The second read port sits on the write address. After each write the write pointer steps onto the oldest stored sample. On the next write that sample is captured into a forwarding register, and this register drives the write port of the next segment directly. No extra copy cycles are needed.

The data interface is a rigid stream with no back-pressure, and there is no ready signal. A write is always accepted in the cycle that `wr_en` is high. The one-cycle `fwd_valid` beat must be consumed by the downstream segment in that same cycle, normally by wiring `fwd_valid` to its `wr_en`. Head and tail segments share one depth. Any leftover depth goes into one or two shorter middle segments, and the package provides a helper that computes their depth.

Top module: `tmfir_delay_seg`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `fwd_valid` is 0, `fwd_data` is 0 and `tap_data` is 0. Every stored entry reads back as 0 until it is first written.
- R2: The k-th write after reset (counting from 0) stores `wr_data` at physical address k mod `DEPTH`. The write pointer wraps from `DEPTH-1` to 0.
- R3: `tap_data` shows, one cycle later, the contents of the entry that `tap_addr` names. If that entry is written in the same cycle, the value returned is the one held before the write.
- R4: `fwd_valid` is high for exactly the one cycle that follows each cycle with `wr_en` high, and is low otherwise.
- R5: When `fwd_valid` is high, `fwd_data` equals the sample written `DEPTH` writes earlier, or 0 if fewer than `DEPTH` writes have occurred since reset.
- R6: A cycle with `wr_en` low changes no stored entry and does not move the write pointer.
- R7: In a chain where each segment's `fwd_valid`/`fwd_data` feeds the next segment's `wr_en`/`wr_data`, a sample written into the head leaves the last segment after as many head writes as the sum of all segment depths.
- R8: Pointer wrap and address placement are correct both when `DEPTH` is a power of two and when it is not.
- R9: The package function `mid_seg_depth(nl, ml, ndm)` returns (nl − ml·(ndm − 2)) / 2, rounded down.
- R10: `fwd_data` keeps its last value in every cycle where `fwd_valid` is low.
- R11: A `tap_addr` of `DEPTH` or more returns 0 on `tap_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one sample this cycle |
| wr_data | input | DATA_W | Sample to store |
| tap_addr | input | AW | Physical entry address for the tap read |
| tap_data | output | DATA_W | Tap read result, one cycle after the address |
| fwd_valid | output | 1 | One-cycle beat carrying the evicted oldest sample |
| fwd_data | output | DATA_W | Evicted oldest sample, held between beats |

## Verification
The bench builds a three-segment chain. The head and tail have depth 4, which is a power of two and takes the free-running pointer variant. The middle segment has depth 3, computed by `mid_seg_depth(17,5,4)`, which takes the compare-and-wrap pointer variant, and its two-bit address lets an out-of-range tap address of 3 be driven. Chaining the segments brings end-to-end delay and forwarding timing under back-to-back writes within reach. It also exercises pacing of one write per five cycles, irregular gaps, and same-cycle tap/write collisions in every segment.

// File: rtl/tmfir_seg_pkg.sv
package tmfir_seg_pkg;

  // Address width for a buffer of the given depth (at least one bit).
  function automatic int unsigned seg_addr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // True when depth is a power of two greater than one.
  function automatic bit is_pow2(input int unsigned depth);
    return (depth > 1) && ((depth & (depth - 1)) == 0);
  endfunction

  // Depth of each shorter middle segment: the stretched tap count minus
  // the full-depth head/tail segments, split over two middle buffers.
  function automatic int mid_seg_depth(input int nl, input int ml, input int ndm);
    return (nl - ml * (ndm - 2)) / 2;
  endfunction

endpackage

// File: rtl/tmfir_seg_wptr.sv
module tmfir_seg_wptr #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam bit FREE_WRAP = tmfir_seg_pkg::is_pow2(DEPTH) && ((1 << AW) == DEPTH);

  generate
    if (FREE_WRAP) begin : g_free
      // Depth fills the address space: natural overflow is the wrap.
      always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tmfir_seg_ram.sv
module tmfir_seg_ram #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 18,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] taddr,
  output logic [DW-1:0] tdata,
  output logic [DW-1:0] oldest
);
  localparam logic [AW:0] LIM = (AW + 1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  // One write, a registered tap read (old data on collision) and an
  // asynchronous read on the write address exposing the oldest entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      tdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      tdata <= ({1'b0, taddr} < LIM) ? mem[taddr] : '0;
    end
  end

  assign oldest = mem[waddr];
endmodule

// File: rtl/tmfir_seg_fwd.sv
module tmfir_seg_fwd #(
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      dvalid <= load;
      if (load) dout <= din;
    end
  end
endmodule

// File: rtl/tmfir_delay_seg.sv
module tmfir_delay_seg
  import tmfir_seg_pkg::*;
#(
  parameter  int unsigned DEPTH  = 8,
  parameter  int unsigned DATA_W = 18,
  localparam int unsigned AW     = seg_addr_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     tap_addr,
  output logic [DATA_W-1:0] tap_data,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data
);
  logic [AW-1:0]     wptr_q;
  logic [DATA_W-1:0] oldest_w;

  tmfir_seg_wptr #(.DEPTH(DEPTH), .AW(AW)) wptr_i (
    .clk (clk),
    .rst (rst),
    .adv (wr_en),
    .ptr (wptr_q)
  );

  tmfir_seg_ram #(.DEPTH(DEPTH), .DW(DATA_W), .AW(AW)) ram_i (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .waddr  (wptr_q),
    .wdata  (wr_data),
    .taddr  (tap_addr),
    .tdata  (tap_data),
    .oldest (oldest_w)
  );

  // The entry under the write pointer is the oldest one; it is handed on
  // in the same cycle it is overwritten.
  tmfir_seg_fwd #(.DW(DATA_W)) fwd_i (
    .clk    (clk),
    .rst    (rst),
    .load   (wr_en),
    .din    (oldest_w),
    .dout   (fwd_data),
    .dvalid (fwd_valid)
  );
endmodule

// File: rtl/tmfir_delay_seg_chk.sv
module tmfir_delay_seg_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 18,
  parameter int unsigned AW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] tap_addr,
  input logic [DW-1:0] tap_data,
  input logic          fwd_valid,
  input logic [DW-1:0] fwd_data,
  input logic [AW-1:0] wptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   LIM  = (AW + 1)'(DEPTH);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!fwd_valid && fwd_data == '0 && tap_data == '0));

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, wptr} < LIM);

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1)));

  assert_fwd_beat_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> fwd_valid);

  assert_fwd_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !fwd_valid);

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wptr));

  assert_fwd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !fwd_valid |-> $stable(fwd_data));

  assert_tap_oor_R11: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, tap_addr} >= LIM) |=> (tap_data == '0));
endmodule

bind tmfir_delay_seg tmfir_delay_seg_chk #(.DEPTH(DEPTH), .DW(DATA_W), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .tap_addr  (tap_addr),
  .tap_data  (tap_data),
  .fwd_valid (fwd_valid),
  .fwd_data  (fwd_data),
  .wptr      (wptr_q)
);

// File: tb/tmfir_delay_seg_tb_top.sv
`timescale 1ns/1ps
module tmfir_delay_seg_tb_top;
  import tmfir_seg_pkg::*;

  localparam int DW    = 12;
  localparam int D0    = 4;
  localparam int D1    = mid_seg_depth(17, 5, 4);
  localparam int D2    = 4;
  localparam int A0    = seg_addr_w(D0);
  localparam int A1    = seg_addr_w(D1);
  localparam int A2    = seg_addr_w(D2);
  localparam int CHAIN = D0 + D1 + D2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          we0;
  logic [DW-1:0] wd0;
  logic [A0-1:0] ta0;
  logic [A1-1:0] ta1;
  logic [A2-1:0] ta2;
  logic [DW-1:0] td0, td1, td2, fd0, fd1, fd2;
  logic          fv0, fv1, fv2;

  tmfir_delay_seg #(.DEPTH(D0), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(we0), .wr_data(wd0), .tap_addr(ta0),
    .tap_data(td0), .fwd_valid(fv0), .fwd_data(fd0));
  tmfir_delay_seg #(.DEPTH(D1), .DATA_W(DW)) seg1_i (
    .clk(clk), .rst(rst), .wr_en(fv0), .wr_data(fd0), .tap_addr(ta1),
    .tap_data(td1), .fwd_valid(fv1), .fwd_data(fd1));
  tmfir_delay_seg #(.DEPTH(D2), .DATA_W(DW)) seg2_i (
    .clk(clk), .rst(rst), .wr_en(fv1), .wr_data(fd1), .tap_addr(ta2),
    .tap_data(td2), .fwd_valid(fv2), .fwd_data(fd2));

  // Behavioural reference: each segment is a FIFO pre-filled with zeros.
  int            dep [3];
  logic [DW-1:0] mq [3][$];
  int            wc [3];
  logic          efv [3];
  logic [DW-1:0] efd [3];
  logic [DW-1:0] etd [3];
  logic [DW-1:0] hist [$];
  int            oc2;
  int            errors = 0;
  int            checks = 0;
  bit            done = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [DW-1:0] wd, input int ta [3]);
    logic          iwe [3];
    logic [DW-1:0] iwd [3];
    logic          nfv [3];
    logic [DW-1:0] nfd [3];
    logic [DW-1:0] ntd [3];
    logic          afv [3];
    logic [DW-1:0] afd [3];
    logic [DW-1:0] atd [3];
    string         rtag [3];
    iwe[0] = we;     iwd[0] = wd;
    iwe[1] = efv[0]; iwd[1] = efd[0];
    iwe[2] = efv[1]; iwd[2] = efd[1];
    we0 = we; wd0 = wd;
    ta0 = A0'(ta[0]); ta1 = A1'(ta[1]); ta2 = A2'(ta[2]);
    for (int s = 0; s < 3; s++) begin
      if (ta[s] >= dep[s]) begin
        ntd[s] = '0;
        rtag[s] = "R11";
      end else begin
        ntd[s] = mq[s][(ta[s] - (wc[s] % dep[s]) + dep[s]) % dep[s]];
        rtag[s] = (s == 1) ? "R2 R3 R8" : "R2 R3";
        if (wc[s] == 0) rtag[s] = {"R1 ", rtag[s]};
      end
      if (iwe[s]) begin
        nfv[s] = 1'b1;
        nfd[s] = mq[s].pop_front();
        mq[s].push_back(iwd[s]);
        wc[s]++;
      end else begin
        nfv[s] = 1'b0;
        nfd[s] = efd[s];
      end
    end
    if (we) hist.push_back(wd);
    @(posedge clk);
    @(negedge clk);
    afv = '{fv0, fv1, fv2};
    afd = '{fd0, fd1, fd2};
    atd = '{td0, td1, td2};
    for (int s = 0; s < 3; s++) begin
      efv[s] = nfv[s]; efd[s] = nfd[s]; etd[s] = ntd[s];
      check($sformatf("%s seg%0d fwd_valid", iwe[s] ? "R4" : "R4 R6", s),
            DW'(afv[s]), DW'(efv[s]));
      check($sformatf("%s seg%0d fwd_data", iwe[s] ? "R5" : "R6 R10", s), afd[s], efd[s]);
      check($sformatf("%s seg%0d tap_data addr=%0d", rtag[s], s, ta[s]), atd[s], etd[s]);
    end
    if (fv2) begin
      check("R7 chain end-to-end delay", fd2, (oc2 >= CHAIN) ? hist[oc2 - CHAIN] : '0);
      oc2++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    we0 = 1'b0; wd0 = '0; ta0 = '0; ta1 = '0; ta2 = '0;
    dep = '{D0, D1, D2};
    oc2 = 0;
    for (int s = 0; s < 3; s++) begin
      wc[s] = 0; efv[s] = 1'b0; efd[s] = '0; etd[s] = '0;
      mq[s].delete();
      repeat (dep[s]) mq[s].push_back('0);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1 reset fwd_valid", DW'({fv0, fv1, fv2}), '0);
    check("R1 reset fwd_data", fd0 | fd1 | fd2, '0);
    check("R1 reset tap_data", td0 | td1 | td2, '0);
    rst = 1'b0;

    // R9: middle-depth helper
    check("R9 mid_seg_depth(17,5,4)", DW'(mid_seg_depth(17, 5, 4)), DW'(3));
    check("R9 mid_seg_depth(20,6,4)", DW'(mid_seg_depth(20, 6, 4)), DW'(4));
    check("R9 mid_seg_depth(40,10,4)", DW'(mid_seg_depth(40, 10, 4)), DW'(10));

    // Post-reset sweep of every entry with no writes (R1, R6)
    for (int i = 0; i < 4; i++) step(1'b0, '0, '{i, i, i});

    // Paced writes: one sample per five cycles
    for (int i = 0; i < 20; i++) begin
      for (int c = 0; c < 5; c++)
        step(c == 0, DW'(i * 53 + 17), '{(i + c) % 4, (i + c) % 4, (i + c + 1) % 4});
    end

    // Back-to-back writes, tap aimed at the entry being written (R3)
    for (int i = 0; i < 16; i++)
      step(1'b1, DW'(i * 91 + 5), '{wc[0] % D0, wc[1] % D1, wc[2] % D2});

    // Irregular gaps
    for (int i = 0; i < 40; i++)
      step(((i * 7) % 5) < 2, DW'(i * 29 + 301), '{i % 4, (i + 2) % 4, (i + 3) % 4});

    for (int i = 0; i < 4; i++) step(1'b0, '0, '{i, i, i});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule